// File: doc/BRIEF.md
# UART Transmitter with Trigger-Level FIFO

This block sends bytes as asynchronous serial frames. Software places bytes in a 16-entry queue over a small register bus. A shifter drains the queue and emits each byte as a frame with one start bit, eight data bits and one stop bit. A baud-tick enable comes from outside the block, and each bit is held for sixteen ticks. A status register has two flags. The space-available flag is raised while the queue holds no more bytes than a programmable threshold. The line-done flag is raised once the queue is empty and the final stop bit has been sent. Either flag can only be cleared by writing zero to it after it has been read as one.

Software polls the space-available flag and tops up the queue when the flag is set, then clears the flag. Frames continue without any idle gap for as long as the queue is refilled in time. The queue fill level can be read in the upper byte of a 16-bit count register. To end a transfer with a break, software clears the transmit enable and turns on the line override with its level bit at zero, which holds the line low.

Top module: `uart_fifo_tx`

Register map (3-bit address, 8-bit write data, 16-bit read data): 0 = control, 1 = queue control, 2 = data (write only), 3 = status, 4 = count.

## Requirements
- R1: After reset the count register (address 4) reads 0x0000 and the queue control register (address 1) reads 3. The count register reports the number of queued bytes (0 to 16) in bits [15:8], with bits [7:0] at zero.
- R2: A write to the data register (address 2) while 16 bytes are queued is dropped, and the count stays at 16.
- R3: Status bit 0 (space-available) is 1 whenever the queued count is at or below the trigger level. The trigger level is 1, 2, 4 or 8, selected by queue control bits [1:0] = 0, 1, 2 or 3. The flag cannot be cleared while that condition holds.
- R4: Writing 0 to a status flag (bit 0 space-available, bit 1 line-done) clears it only if that flag was read as 1 since the last write to the status register. Writing 0 to a flag that has not been read as 1 leaves it unchanged. Both flags read 1 after reset.
- R5: Status bit 1 (line-done) is 1 whenever the queue is empty and no frame is in progress, which includes the time after the last stop bit has finished.
- R6: Each frame is a low start bit, then 8 data bits with the LSB first, then a high stop bit. Every bit lasts 16 baud ticks.
- R7: When bytes are waiting, the next frame's start bit follows the previous stop bit with no idle time, so frame starts are exactly 160 ticks apart.
- R8: With control bit 0 (transmit enable) at 0 and the override off, the line stays high, nothing is sent and queued bytes are kept. Setting the enable sends them.
- R9: With transmit enable at 0 and control bit 1 (line override) at 1, the line follows control bit 2 (override level). A level of 0 gives a break.
- R10: Writing 1 to queue control bit 2 empties the queue at once. The discarded bytes are never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading the status register arms flag clearing) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| baud_tick | input | 1 | One-cycle enable, 16 per bit time |
| txd | output | 1 | Serial output line |

## Verification
The bench targets the clear handshake in three cases: a zero written without a prior read, a zero written after a read, and a read taken while the flag was already low. A design that skipped the read-arm step would drop the flags as soon as they were written. The bench steps through all four trigger levels with a fixed fill count, so an off-by-one compare would show up as a wrong flag value at the boundary. It overfills the queue by one byte and then checks both the count and the sixteen frames that follow. A wrapping pointer would corrupt the count or send a stray byte. It times frame starts across a full burst to catch a one-tick idle gap between frames, and it checks that disabled, flushed and overridden states hold the line without sending anything.

// File: rtl/uart_fifo_tx_pkg.sv
package uart_fifo_tx_pkg;

    typedef enum logic [2:0] {
        ADDR_CTRL  = 3'd0,
        ADDR_QCTL  = 3'd1,
        ADDR_DATA  = 3'd2,
        ADDR_STAT  = 3'd3,
        ADDR_COUNT = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic brk_lvl;
        logic brk_en;
        logic tx_en;
    } line_ctrl_t;

    typedef struct packed {
        logic line_done;
        logic space_avail;
    } tx_flags_t;

    typedef enum logic {
        SH_IDLE  = 1'b0,
        SH_SHIFT = 1'b1
    } shift_state_e;

    localparam int FRAME_BITS = 10;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        return 32'd1 << sel;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             empty
);
    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R1
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import uart_fifo_tx_pkg::*;
#(
    parameter int TICKS = 16,
    localparam int TICK_W = (TICKS > 1) ? $clog2(TICKS) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       baud_tick,
    input  logic       q_empty,
    input  logic [7:0] q_head,
    output logic       pop,
    output logic       busy,
    output logic       ser_bit
);
    shift_state_e            state;
    logic [FRAME_BITS-1:0]   frame;
    logic [3:0]              bit_idx;
    logic [TICK_W-1:0]       tick_cnt;
    logic                    bit_end, frame_end;

    assign bit_end   = baud_tick && (tick_cnt == TICK_W'(TICKS - 1));
    assign frame_end = bit_end && (bit_idx == 4'(FRAME_BITS - 1));
    assign pop       = tx_en && !q_empty && ((state == SH_IDLE) || frame_end);
    assign busy      = (state == SH_SHIFT);
    assign ser_bit   = frame[0];

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            state    <= SH_IDLE;
            frame    <= '1;
            bit_idx  <= '0;
            tick_cnt <= '0;
        end else if (pop) begin
            state    <= SH_SHIFT;
            frame    <= build_frame(q_head);
            bit_idx  <= '0;
            tick_cnt <= '0;
        end else if (state == SH_SHIFT && baud_tick) begin
            if (frame_end) begin
                state    <= SH_IDLE;
                frame    <= '1;
                tick_cnt <= '0;
            end else if (bit_end) begin
                tick_cnt <= '0;
                bit_idx  <= bit_idx + 1'b1;
                frame    <= {1'b1, frame[FRAME_BITS-1:1]};
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // R6
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !ser_bit);

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !busy);

endmodule

// File: rtl/utx_regs.sv
module utx_regs
    import uart_fifo_tx_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic [CNT_W-1:0] q_count,
    input  logic             q_empty,
    input  logic             sh_busy,
    output line_ctrl_t       ctrl,
    output logic             q_push,
    output logic [7:0]       q_data,
    output logic             q_clr
);
    logic [1:0]  trig_sel;
    tx_flags_t   flags, armed;
    logic        stat_wr, stat_rd, tdfe_set, tend_set;
    logic [CNT_W-1:0] trig_cnt;

    assign trig_cnt = CNT_W'(trig_level(trig_sel));
    assign stat_wr  = bus_wr && (bus_addr == ADDR_STAT);
    assign stat_rd  = bus_rd && (bus_addr == ADDR_STAT);
    assign tdfe_set = (q_count <= trig_cnt);
    assign tend_set = q_empty && !sh_busy;
    assign q_push   = bus_wr && (bus_addr == ADDR_DATA);
    assign q_data   = bus_wdata;
    assign q_clr    = bus_wr && (bus_addr == ADDR_QCTL) && bus_wdata[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            trig_sel <= 2'd3;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CTRL) ctrl <= line_ctrl_t'(bus_wdata[2:0]);
            if (bus_addr == ADDR_QCTL) trig_sel <= bus_wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '{line_done: 1'b1, space_avail: 1'b1};
            armed <= '0;
        end else begin
            if (tdfe_set)
                flags.space_avail <= 1'b1;
            else if (stat_wr && !bus_wdata[0] && armed.space_avail)
                flags.space_avail <= 1'b0;
            if (tend_set)
                flags.line_done <= 1'b1;
            else if (stat_wr && !bus_wdata[1] && armed.line_done)
                flags.line_done <= 1'b0;
            if (stat_wr) begin
                armed <= '0;
            end else if (stat_rd) begin
                if (flags.space_avail) armed.space_avail <= 1'b1;
                if (flags.line_done)   armed.line_done   <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = {13'd0, ctrl};
            ADDR_QCTL:  bus_rdata = {14'd0, trig_sel};
            ADDR_STAT:  bus_rdata = {14'd0, flags};
            ADDR_COUNT: bus_rdata = {8'(q_count), 8'h00};
            default:    bus_rdata = '0;
        endcase
    end

    // R4
    tdfe_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.space_avail) |-> $past(stat_wr && !bus_wdata[0]));

    // R4
    tend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.line_done) |-> $past(stat_wr && !bus_wdata[1]));

    // R3
    tdfe_level_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.space_avail) |-> ($past(q_count) > $past(trig_cnt)));

    // R5
    tend_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.line_done) |-> $past(!q_empty || sh_busy));

endmodule

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx
    import uart_fifo_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TICKS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        baud_tick,
    output logic        txd
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    line_ctrl_t       ctrl;
    logic             q_push, q_clr, q_pop, q_empty, sh_busy, ser_bit;
    logic [7:0]       q_data, q_head;
    logic [CNT_W-1:0] q_count;

    utx_regs #(.CNT_W(CNT_W)) u_regs (
        .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .q_count, .q_empty, .sh_busy, .ctrl, .q_push, .q_data, .q_clr
    );

    utx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk, .rst, .clr(q_clr), .push(q_push), .push_data(q_data),
        .pop(q_pop), .head(q_head), .count(q_count), .empty(q_empty)
    );

    utx_shifter #(.TICKS(TICKS)) u_shift (
        .clk, .rst, .tx_en(ctrl.tx_en), .baud_tick, .q_empty, .q_head,
        .pop(q_pop), .busy(sh_busy), .ser_bit
    );

    always_comb begin
        if (!ctrl.tx_en && ctrl.brk_en) txd = ctrl.brk_lvl;
        else if (sh_busy)               txd = ser_bit;
        else                            txd = 1'b1;
    end

    // R8
    no_pop_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.tx_en |-> !q_pop);

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        q_clr |=> q_empty);

endmodule

// File: tb/uart_fifo_tx_tb.sv
module uart_fifo_tx_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        baud_tick = 1'b1;
    logic        txd;

    uart_fifo_tx u_dut (
        .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .baud_tick, .txd
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errs = 0, checks = 0;
    int cyc = 0;
    logic [7:0] exp_q[$];
    int frames_seen = 0;
    bit mon_en = 1'b1;
    bit b2b_chk = 1'b0;
    int burst_n = 0;
    int last_start = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b, input bit kept);
        wr(3'd2, b);
        if (kept) exp_q.push_back(b);
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (20) @(negedge clk);
    endtask

    // Monitor: decodes frames on txd, compares with the scoreboard queue
    always begin
        @(negedge clk);
        if (mon_en && txd === 1'b0) begin
            int st;
            logic [7:0] got;
            st = cyc;
            if (b2b_chk && burst_n > 0)
                check(st - last_start == 160, "R7", "frame start spacing", st - last_start, 160);
            repeat (8) @(negedge clk);
            check(txd === 1'b0, "R6", "start bit level", txd, 0);
            for (int i = 0; i < 8; i++) begin
                repeat (16) @(negedge clk);
                got[i] = txd;
            end
            repeat (16) @(negedge clk);
            check(txd === 1'b1, "R6", "stop bit level", txd, 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected frame", got, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(got == e, "R6", "frame data", got, e);
            end
            frames_seen++;
            burst_n++;
            last_start = st;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        int f0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(3'd4, r); check(r == 16'h0000, "R1", "count after reset", r, 0);
        rd(3'd1, r); check(r == 16'd3, "R1", "trigger select after reset", r, 3);
        rd(3'd0, r); check(r == 16'd0, "R8", "control after reset", r, 0);

        // fill 3 bytes with TE off, trigger 1
        wr(3'd1, 8'd0);
        push_byte(8'hA5, 1); push_byte(8'h00, 1); push_byte(8'hFF, 1);
        rd(3'd4, r); check(r == 16'h0300, "R1", "count of 3", r, 16'h0300);
        wr(3'd3, 8'd0);
        rd(3'd3, r); check(r == 16'd3, "R4", "unarmed clear ignored", r, 3);
        wr(3'd3, 8'd0);
        rd(3'd3, r); check(r == 16'd0, "R4", "armed clear", r, 0);

        // trigger levels with count 3
        wr(3'd1, 8'd1);
        rd(3'd3, r); check(r[0] == 1'b0, "R3", "3 above trigger 2", r[0], 0);
        wr(3'd1, 8'd2);
        rd(3'd3, r); check(r[0] == 1'b1, "R3", "3 at or below trigger 4", r[0], 1);
        wr(3'd1, 8'd3);
        rd(3'd3, r); check(r[0] == 1'b1, "R3", "3 at or below trigger 8", r[0], 1);
        wr(3'd3, 8'd0);
        rd(3'd3, r); check(r[0] == 1'b1, "R3", "clear blocked while below trigger", r[0], 1);
        wr(3'd1, 8'd0);
        wr(3'd3, 8'd0);
        rd(3'd3, r); check(r[0] == 1'b0, "R4", "clear after re-read", r[0], 0);

        // TE off holds data
        f0 = frames_seen;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) check(1'b0, "R8", "line idle high", txd, 1);
        end
        check(frames_seen == f0, "R8", "no frames while disabled", frames_seen - f0, 0);
        rd(3'd4, r); check(r == 16'h0300, "R8", "bytes kept while disabled", r, 16'h0300);
        wr(3'd0, 8'd1);
        drain();
        check(frames_seen == f0 + 3, "R8", "frames after enable", frames_seen - f0, 3);
        rd(3'd3, r); check(r[1] == 1'b1, "R5", "line done after drain", r[1], 1);

        // flush
        wr(3'd0, 8'd0);
        push_byte(8'h11, 0); push_byte(8'h22, 0);
        wr(3'd1, 8'd4);
        rd(3'd4, r); check(r == 16'h0000, "R10", "count after flush", r, 0);
        rd(3'd3, r); check(r == 16'd3, "R10", "flags after flush", r, 3);
        f0 = frames_seen;
        wr(3'd0, 8'd1);
        repeat (400) @(negedge clk);
        check(frames_seen == f0, "R10", "flushed bytes not sent", frames_seen - f0, 0);

        // overfill then burst
        wr(3'd0, 8'd0);
        for (int i = 0; i < 16; i++) push_byte(8'(i * 37 + 1), 1);
        push_byte(8'h80, 0);
        rd(3'd4, r); check(r == 16'h1000, "R2", "count stays 16 when full", r, 16'h1000);
        burst_n = 0; b2b_chk = 1'b1;
        f0 = frames_seen;
        wr(3'd0, 8'd1);
        drain();
        b2b_chk = 1'b0;
        check(frames_seen == f0 + 16, "R2", "exactly 16 frames", frames_seen - f0, 16);
        rd(3'd3, r); check(r[1] == 1'b1, "R5", "line done after burst", r[1], 1);
        wr(3'd3, 8'd0);
        rd(3'd3, r); check(r[1] == 1'b1, "R5", "line done held while idle", r[1], 1);

        // break via override
        mon_en = 1'b0;
        wr(3'd0, 8'd2);
        @(negedge clk); check(txd === 1'b0, "R9", "break low", txd, 0);
        wr(3'd0, 8'd6);
        @(negedge clk); check(txd === 1'b1, "R9", "override level high", txd, 1);
        wr(3'd0, 8'd3);
        @(negedge clk); check(txd === 1'b1, "R9", "override ignored with TE on", txd, 1);
        wr(3'd0, 8'd0);
        @(negedge clk); check(txd === 1'b1, "R8", "idle high after override off", txd, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule